// File: doc/BRIEF.md
# Automatic Transmit/Receive Pin Switcher

This block drives a set of general-purpose I/O banks whose pins must change with the radio's direction. A one-bit input reports whether the transmit FIFO holds data. The block turns that input into a transmit/receive state. The state moves to transmit only after a programmable settling delay, and back to receive only after a second delay that is programmed separately. If the FIFO input reverses before a delay runs out, the pending change is dropped.

For every bank, a mask picks which pins follow the automatic pattern. Masked pins show either the bank's transmit pattern or its receive pattern, depending on the delayed state. Unmasked pins pass the ordinary output register value through unchanged. A global enable turns automatic switching off, and then every pin carries its ordinary value. The delayed state is also brought out on its own pin so that other logic can use it. The FIFO and the register host interface are outside this block, and all register values arrive as plain input vectors.

Top module: `trsw_pin_switch`

## Requirements
- R1: After reset the transmit/receive state output is 0, which means receive. No delay is pending at that point.
- R2: Whatever the state or the enable, a pin whose mask bit is 0 carries the bit at the same position of the ordinary output register.
- R3: While the enable is 1 and the state is 1 (transmit), a pin whose mask bit is 1 carries the matching transmit-pattern bit.
- R4: While the enable is 1 and the state is 0 (receive), a pin whose mask bit is 1 carries the matching receive-pattern bit.
- R5: With the state at 0, the state becomes 1 at the clock edge numbered rise-delay + 1 among consecutive edges that sample the FIFO input as 1.
- R6: With the state at 1, the state becomes 0 at the clock edge numbered fall-delay + 1 among consecutive edges that sample the FIFO input as 0.
- R7: A delay value of 0 makes the matching transition happen at the first clock edge that samples the new FIFO value.
- R8: If the FIFO input returns to the value that matches the current state before a delay completes, the state does not change. A later transition then waits for its full delay again.
- R9: While the enable is 0, every pin equals the ordinary output register, and the state keeps following the FIFO input with its delays.
- R10: Bank k uses bits [16k+15:16k] of each of the mask, transmit-pattern, receive-pattern, ordinary-register and pin vectors. Each bank is switched independently of the others.
- R11: The pin outputs react to the mask, pattern, ordinary-register and enable inputs without a clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_en_i | input | 1 | Global enable for automatic switching |
| fifo_has_data_i | input | 1 | 1 while the transmit FIFO is not empty |
| rise_dly_i | input | 8 | Extra ticks before entering transmit |
| fall_dly_i | input | 8 | Extra ticks before returning to receive |
| mask_i | input | 64 | Per-pin automatic-control mask, all banks |
| txval_i | input | 64 | Transmit pattern, all banks |
| rxval_i | input | 64 | Receive pattern, all banks |
| ioval_i | input | 64 | Ordinary output register value, all banks |
| pins_o | output | 64 | Resulting pin values, all banks |
| tx_state_o | output | 1 | Delayed transmit/receive state |

## Verification
A wrong delay count shows up on tx_state_o and on every masked pin at the same time. The transition lands one or more edges before or after edge number delay + 1, so each delay test samples the state both one edge before and exactly at the expected edge. A counter that is not cleared when the FIFO input reverses makes the next transition arrive early, and the bench catches this with a cancel-then-retry sequence. A wrong bank slice or a wrong mask polarity corrupts the pins at once, in the same cycle, for fixed register values that differ from bank to bank.

// File: rtl/trsw_pkg.sv
package trsw_pkg;
   typedef enum logic {
      ST_RX = 1'b0,
      ST_TX = 1'b1
   } trsw_state_e;

   function automatic logic [31:0] trsw_clog2_min1(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return (r == 0) ? 32'd1 : r;
   endfunction
endpackage

// File: rtl/trsw_edge_delay.sv
module trsw_edge_delay
   import trsw_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy_i,
   input  logic [DLY_W-1:0] rise_dly_i,
   input  logic [DLY_W-1:0] fall_dly_i,
   output trsw_state_e      state_o
);
   trsw_state_e      state_q;
   trsw_state_e      want;
   logic [DLY_W-1:0] cnt_q;
   logic [DLY_W-1:0] target;

   initial begin
      assert (DLY_W >= 1 && DLY_W <= 31)
         else $error("trsw_edge_delay: DLY_W out of range");
   end

   assign want   = busy_i ? ST_TX : ST_RX;
   assign target = (state_q == ST_TX) ? fall_dly_i : rise_dly_i;

   // Counts edges since the mismatch began; compare with >= so that a
   // delay lowered mid-count still ends the wait at once.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RX;
         cnt_q   <= '0;
      end else if (want == state_q) begin
         cnt_q   <= '0;
      end else if (cnt_q >= target) begin
         state_q <= want;
         cnt_q   <= '0;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign state_o = state_q;

   p_hold_on_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i == state_q) |=> (state_q == $past(state_q)));

   p_zero_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RX && busy_i && rise_dly_i == '0) |=> (state_q == ST_TX));

   p_zero_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TX && !busy_i && fall_dly_i == '0) |=> (state_q == ST_RX));

   p_rise_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RX && busy_i && cnt_q < rise_dly_i) |=> (state_q == ST_RX));

   p_fall_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_TX && !busy_i && cnt_q < fall_dly_i) |=> (state_q == ST_TX));

   p_idle_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i == state_q) |=> (cnt_q == '0));
endmodule

// File: rtl/trsw_bank_sel.sv
module trsw_bank_sel
   import trsw_pkg::*;
#(
   parameter int W = 16
) (
   input  logic        en_i,
   input  trsw_state_e state_i,
   input  logic [W-1:0] mask_i,
   input  logic [W-1:0] txval_i,
   input  logic [W-1:0] rxval_i,
   input  logic [W-1:0] ioval_i,
   output logic [W-1:0] pin_o
);
   logic [W-1:0] pattern;
   logic [W-1:0] eff_mask;

   initial begin
      assert (W >= 1) else $error("trsw_bank_sel: W must be positive");
   end

   always_comb begin
      pattern  = (state_i == ST_TX) ? txval_i : rxval_i;
      eff_mask = en_i ? mask_i : '0;
      pin_o    = (pattern & eff_mask) | (ioval_i & ~eff_mask);
   end
endmodule

// File: rtl/trsw_out_stage.sv
module trsw_out_stage #(
   parameter int WIDTH   = 64,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (OUT_REG) begin : g_reg
         logic [WIDTH-1:0] q_q;
         always_ff @(posedge clk) begin
            if (!rst_n) q_q <= '0;
            else        q_q <= d_i;
         end
         assign q_o = q_q;
      end else begin : g_pass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q_o = d_i;
      end
   endgenerate
endmodule

// File: rtl/trsw_pin_switch.sv
module trsw_pin_switch
   import trsw_pkg::*;
#(
   parameter int NBANK   = 4,
   parameter int BANK_W  = 16,
   parameter int DLY_W   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    auto_en_i,
   input  logic                    fifo_has_data_i,
   input  logic [DLY_W-1:0]        rise_dly_i,
   input  logic [DLY_W-1:0]        fall_dly_i,
   input  logic [NBANK*BANK_W-1:0] mask_i,
   input  logic [NBANK*BANK_W-1:0] txval_i,
   input  logic [NBANK*BANK_W-1:0] rxval_i,
   input  logic [NBANK*BANK_W-1:0] ioval_i,
   output logic [NBANK*BANK_W-1:0] pins_o,
   output logic                    tx_state_o
);
   localparam int TOT_W  = NBANK * BANK_W;
   localparam int BANK_IW = trsw_clog2_min1(NBANK);

   trsw_state_e      state;
   logic [TOT_W-1:0] pins_comb;

   initial begin
      assert (NBANK >= 1 && NBANK <= 64)
         else $error("trsw_pin_switch: NBANK out of range");
      assert (BANK_W >= 1 && BANK_IW >= 1)
         else $error("trsw_pin_switch: BANK_W must be positive");
   end

   trsw_edge_delay #(.DLY_W(DLY_W)) u_dly (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (fifo_has_data_i),
      .rise_dly_i (rise_dly_i),
      .fall_dly_i (fall_dly_i),
      .state_o    (state)
   );

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         trsw_bank_sel #(.W(BANK_W)) u_sel (
            .en_i    (auto_en_i),
            .state_i (state),
            .mask_i  (mask_i [b*BANK_W +: BANK_W]),
            .txval_i (txval_i[b*BANK_W +: BANK_W]),
            .rxval_i (rxval_i[b*BANK_W +: BANK_W]),
            .ioval_i (ioval_i[b*BANK_W +: BANK_W]),
            .pin_o   (pins_comb[b*BANK_W +: BANK_W])
         );

         if (!OUT_REG) begin : g_chk
            p_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
               ((pins_o[b*BANK_W +: BANK_W] ^ ioval_i[b*BANK_W +: BANK_W])
                 & ~mask_i[b*BANK_W +: BANK_W]) == '0);
            p_tx_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
               (auto_en_i && tx_state_o) |->
               (((pins_o[b*BANK_W +: BANK_W] ^ txval_i[b*BANK_W +: BANK_W])
                 & mask_i[b*BANK_W +: BANK_W]) == '0));
         end
      end
   endgenerate

   trsw_out_stage #(.WIDTH(TOT_W), .OUT_REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_comb),
      .q_o   (pins_o)
   );

   assign tx_state_o = (state == ST_TX);

   generate
      if (!OUT_REG) begin : g_top_chk
         p_disabled_io_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !auto_en_i |-> (pins_o == ioval_i));
      end
   endgenerate

   p_reset_rx_r1: assert property (@(posedge clk)
      !rst_n |=> !tx_state_o);
endmodule

// File: tb/sim_trsw_pin_switch.sv
module sim_trsw_pin_switch;
   localparam int NB = 4;
   localparam int BW = 16;
   localparam int TW = NB * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          fifo = 1'b0;
   logic [7:0]    rise = 8'd0;
   logic [7:0]    fall = 8'd0;
   logic [TW-1:0] mask = '0;
   logic [TW-1:0] txv = '0;
   logic [TW-1:0] rxv = '0;
   logic [TW-1:0] iov = '0;
   logic [TW-1:0] pins;
   logic          st;

   int checks = 0;
   int errors = 0;
   logic st_exp = 1'b0;

   always #5 clk = ~clk;

   trsw_pin_switch u0 (
      .clk(clk), .rst_n(rst_n), .auto_en_i(en), .fifo_has_data_i(fifo),
      .rise_dly_i(rise), .fall_dly_i(fall), .mask_i(mask), .txval_i(txv),
      .rxval_i(rxv), .ioval_i(iov), .pins_o(pins), .tx_state_o(st)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [TW-1:0] model(input logic s);
      logic [TW-1:0] p;
      p = s ? txv : rxv;
      return en ? ((p & mask) | (iov & ~mask)) : iov;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_regs();
      for (int k = 0; k < NB; k++) begin
         mask[k*BW +: BW] = 16'hF0F0 ^ (16'h1111 * k);
         txv [k*BW +: BW] = 16'hA5A5 + 16'h0101 * k;
         rxv [k*BW +: BW] = 16'h3C3C ^ (16'h0F00 >> k);
         iov [k*BW +: BW] = 16'h6996 - 16'h0011 * k;
      end
   endtask

   task automatic t_reset();
      tick(1);
      chk("R1 state after reset", {63'd0, st}, 64'd0);
      en = 1'b1;
      #1;
      chk("R4 rx pattern after reset", pins, model(1'b0));
      chk("R11 pins follow enable in same cycle", pins, model(1'b0));
   endtask

   task automatic t_rise();
      rise = 8'd3; fall = 8'd2;
      fifo = 1'b1;
      tick(3);
      chk("R5 still rx one edge early", {63'd0, st}, 64'd0);
      tick(1);
      chk("R5 tx at edge rise+1", {63'd0, st}, 64'd1);
      chk("R3 tx pattern on masked pins", pins, model(1'b1));
   endtask

   task automatic t_fall();
      fifo = 1'b0;
      tick(2);
      chk("R6 still tx one edge early", {63'd0, st}, 64'd1);
      tick(1);
      chk("R6 rx at edge fall+1", {63'd0, st}, 64'd0);
      chk("R4 rx pattern after fall", pins, model(1'b0));
   endtask

   task automatic t_zero();
      rise = 8'd0; fall = 8'd0;
      fifo = 1'b1;
      tick(1);
      chk("R7 zero rise delay", {63'd0, st}, 64'd1);
      fifo = 1'b0;
      tick(1);
      chk("R7 zero fall delay", {63'd0, st}, 64'd0);
   endtask

   task automatic t_cancel();
      rise = 8'd4; fall = 8'd3;
      fifo = 1'b1;
      tick(2);
      fifo = 1'b0;
      tick(1);
      chk("R8 rise cancelled", {63'd0, st}, 64'd0);
      fifo = 1'b1;
      tick(4);
      chk("R8 rise restarts full delay", {63'd0, st}, 64'd0);
      tick(1);
      chk("R8 rise completes after restart", {63'd0, st}, 64'd1);
      fifo = 1'b0;
      tick(2);
      fifo = 1'b1;
      tick(1);
      chk("R8 fall cancelled", {63'd0, st}, 64'd1);
      fifo = 1'b0;
      tick(3);
      chk("R8 fall restarts full delay", {63'd0, st}, 64'd1);
      tick(1);
      chk("R8 fall completes after restart", {63'd0, st}, 64'd0);
   endtask

   task automatic t_disable();
      en = 1'b0;
      rise = 8'd1; fall = 8'd1;
      #1;
      chk("R9 disabled rx gives io", pins, iov);
      fifo = 1'b1;
      tick(2);
      chk("R9 state tracks while disabled", {63'd0, st}, 64'd1);
      chk("R9 disabled tx gives io", pins, iov);
      en = 1'b1;
      #1;
      chk("R3 re-enabled tx pattern", pins, model(1'b1));
   endtask

   task automatic t_banks();
      for (int k = 0; k < NB; k++) begin
         mask[k*BW +: BW] = 16'h0001 << (4 * k);
         iov [k*BW +: BW] = 16'h0000;
         txv [k*BW +: BW] = 16'hFFFF;
      end
      #1;
      for (int k = 0; k < NB; k++) begin
         chk($sformatf("R10 bank %0d slice", k), {48'd0, pins[k*BW +: BW]},
             {48'd0, 16'h0001 << (4 * k)});
      end
      iov = {TW{1'b1}};
      #1;
      chk("R2 unmasked pins keep io", pins & ~mask, ~mask);
      fifo = 1'b0;
      tick(2);
      chk("R4 masked rx pattern per bank", pins, model(1'b0));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      load_regs();
      tick(3);
      rst_n = 1'b1;
      t_reset();
      t_rise();
      t_fall();
      t_zero();
      t_cancel();
      t_disable();
      t_banks();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule